// File: doc/BRIEF.md
# Global-Clock Emulated Asynchronous Register

This block stands in for a register with its own clock and asynchronous controls when everything has to run from one fast global clock, as in formal-style proofs of multi-clock designs. Every input is registered once per global cycle. The output `q` is then formed combinationally from these registered ("sampled") values and the live ("current") values. A rising or falling edge of the emulated clock is seen as a change between the sampled and the current clock level.

Each asynchronous control is applied twice, in a fixed order. The first pass uses only sampled values and the second uses only current values. This means that controls and clock edges arriving in the same global cycle always give one defined result. Generics pick the width, the polarity of each control, the reset value and the power-up value, and they switch the load, set/clear and reset features on or off. `q` is a plain level output with no handshake, because the block models a single flop and carries no stream.

Top module: `clk_emu_ff`

## Requirements
- R1: While `grst` is high, every internal sample register returns to its start state: the sampled `q` becomes `INIT_VAL`, and the sampled data, load data and controls become zero/inactive. When no clock edge and no control is active, `q` equals the `q` of the previous global cycle.
- R2: An emulated edge exists when (sampled, current) clock equals (0,1) for `CLK_POL`=1 or (1,0) for `CLK_POL`=0. The sampled clock starts at 1 for `CLK_POL`=1 and at 0 for `CLK_POL`=0, so the first level seen after `grst` never forms an edge.
- R3: On an emulated edge, `q` takes the `din` of the previous global cycle, not the present `din`.
- R4: Each control is active when its level equals its polarity parameter (1 = active high). Defaults: load, set and clear are active high; `arst` is active low.
- R5: After the edge selection, the sampled pass runs first and the current pass second. Within each pass the order is load, then set/clear, then reset. For example, a current load overrides a sampled clear.
- R6: An active load puts load data on `q`. In the sampled pass this is the sampled `ld_din`; in the current pass it is the live `ld_din`.
- R7: Set and clear act per bit as (q | set) & ~clear, so clear beats set on the same bit.
- R8: While `arst` is currently active, `q` equals `RST_VAL`.
- R9: In the global cycle in which `arst` goes inactive, and after that cycle, `q` keeps `RST_VAL` even if an emulated edge occurs in that cycle. Data is only taken again at a later edge.
- R10: A disabled feature (`HAS_LOAD`, `HAS_SETCLR`, `HAS_ARST` = 0) builds no logic, and its input pins have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock; all sampling happens on its rising edge |
| grst | input | 1 | Synchronous global reset, puts the sample registers in their start state |
| emu_clk | input | 1 | Emulated register clock, treated as a data level |
| din | input | WIDTH | Data captured on an emulated edge |
| ld | input | 1 | Asynchronous load enable |
| ld_din | input | WIDTH | Asynchronous load data |
| setb | input | WIDTH | Per-bit asynchronous set |
| clrb | input | WIDTH | Per-bit asynchronous clear |
| arst | input | 1 | Asynchronous reset to `RST_VAL` |
| q | output | WIDTH | Emulated register output |

## Verification
The checker assumes that every input changes only between rising edges of `gclk` and that `grst` is high at the first edge. Its properties are conditioned on the past cycle not being a reset cycle. It also expects that no other control is active when it checks a single rule such as the data capture or the load. The stimulus drives all pins right after the falling edge of `gclk` and starts with `grst` asserted. It keeps load, reset, set and clear sparse, so that there are many quiet intervals for the edge and hold properties to fire. It still mixes controls with clock edges often enough to exercise the two-pass ordering.

// File: rtl/cef_pkg.sv
package cef_pkg;
  // The two resolution passes, in the order they are applied.
  typedef enum logic {
    PASS_SAMPLED = 1'b0,
    PASS_CURRENT = 1'b1
  } pass_e;

  localparam int NUM_PASSES = 2;

  // Convert a raw level to active-high according to the polarity bit.
  function automatic logic to_active(input logic pol, input logic lvl);
    return pol ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/cef_data_sampler.sv
module cef_data_sampler #(
  parameter int              WIDTH = 8,
  parameter logic [WIDTH-1:0] START = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] now,
  output logic [WIDTH-1:0] smp
);
  always_ff @(posedge clk) begin
    if (rst) smp <= START;
    else     smp <= now;
  end
endmodule

// File: rtl/cef_ctl_sampler.sv
module cef_ctl_sampler #(
  parameter int   WIDTH = 1,
  parameter logic POL   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] act_now,
  output logic [WIDTH-1:0] act_smp
);
  // Active-high view of the control, then one register that starts inactive.
  generate
    if (POL) begin : g_high
      assign act_now = raw;
    end else begin : g_low
      assign act_now = ~raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) act_smp <= '0;
    else     act_smp <= act_now;
  end
endmodule

// File: rtl/cef_edge_detect.sv
module cef_edge_detect #(
  parameter logic POL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic hit
);
  logic lvl_smp;

  // The start value can never pair with the next sample into an edge.
  always_ff @(posedge clk) begin
    if (rst) lvl_smp <= POL;
    else     lvl_smp <= lvl;
  end

  generate
    if (POL) begin : g_rise
      assign hit = ~lvl_smp & lvl;
    end else begin : g_fall
      assign hit = lvl_smp & ~lvl;
    end
  endgenerate
endmodule

// File: rtl/cef_pass_stage.sv
module cef_pass_stage #(
  parameter int               WIDTH      = 8,
  parameter bit               HAS_LOAD   = 1'b1,
  parameter bit               HAS_SETCLR = 1'b1,
  parameter bit               HAS_ARST   = 1'b1,
  parameter logic [WIDTH-1:0] RST_VAL    = '0
) (
  input  logic [WIDTH-1:0] q_in,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_data,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  input  logic             rst,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] after_ld, after_sr;

  // Order inside one pass: load, then set/clear, then reset.
  generate
    if (HAS_LOAD) begin : g_ld
      assign after_ld = ld ? ld_data : q_in;
    end else begin : g_no_ld
      logic ld_unused;
      assign ld_unused = ^{ld, ld_data};
      assign after_ld  = q_in;
    end

    if (HAS_SETCLR) begin : g_sr
      assign after_sr = (after_ld | set) & ~clr;
    end else begin : g_no_sr
      logic sr_unused;
      assign sr_unused = ^{set, clr};
      assign after_sr  = after_ld;
    end

    if (HAS_ARST) begin : g_rst
      assign q_out = rst ? RST_VAL : after_sr;
    end else begin : g_no_rst
      logic rst_unused;
      assign rst_unused = rst;
      assign q_out      = after_sr;
    end
  endgenerate
endmodule

// File: rtl/clk_emu_ff.sv
module clk_emu_ff
  import cef_pkg::*;
#(
  parameter int               WIDTH      = 8,
  parameter logic             CLK_POL    = 1'b1,
  parameter bit               HAS_LOAD   = 1'b1,
  parameter logic             LOAD_POL   = 1'b1,
  parameter bit               HAS_SETCLR = 1'b1,
  parameter logic             SET_POL    = 1'b1,
  parameter logic             CLR_POL    = 1'b1,
  parameter bit               HAS_ARST   = 1'b1,
  parameter logic             ARST_POL   = 1'b0,
  parameter logic [WIDTH-1:0] RST_VAL    = WIDTH'('hA5),
  parameter logic [WIDTH-1:0] INIT_VAL   = WIDTH'('h3C)
) (
  input  logic             gclk,
  input  logic             grst,
  input  logic             emu_clk,
  input  logic [WIDTH-1:0] din,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_din,
  input  logic [WIDTH-1:0] setb,
  input  logic [WIDTH-1:0] clrb,
  input  logic             arst,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] q_smp, d_smp, edge_q;
  logic             clk_hit;

  // Per-pass control views: *_s sampled, *_c current (all active high).
  logic             ld_s, ld_c, rst_s, rst_c;
  logic [WIDTH-1:0] ldd_s, ldd_c, set_s, set_c, clr_s, clr_c;
  logic [WIDTH-1:0] mid_q;

  cef_data_sampler #(.WIDTH(WIDTH), .START(INIT_VAL)) u_q_smp (
    .clk(gclk), .rst(grst), .now(q), .smp(q_smp)
  );

  // The start value of the sampled data is never observed.
  cef_data_sampler #(.WIDTH(WIDTH), .START(ZERO)) u_d_smp (
    .clk(gclk), .rst(grst), .now(din), .smp(d_smp)
  );

  cef_edge_detect #(.POL(CLK_POL)) u_edge (
    .clk(gclk), .rst(grst), .lvl(emu_clk), .hit(clk_hit)
  );

  generate
    if (HAS_LOAD) begin : g_load
      cef_ctl_sampler #(.WIDTH(1), .POL(LOAD_POL)) u_ld (
        .clk(gclk), .rst(grst), .raw(ld), .act_now(ld_c), .act_smp(ld_s)
      );
      cef_data_sampler #(.WIDTH(WIDTH), .START(ZERO)) u_ldd (
        .clk(gclk), .rst(grst), .now(ld_din), .smp(ldd_s)
      );
      assign ldd_c = ld_din;
    end else begin : g_no_load
      logic load_unused;
      assign load_unused = ^{ld, ld_din};
      assign ld_s  = 1'b0;
      assign ld_c  = 1'b0;
      assign ldd_s = '0;
      assign ldd_c = '0;
    end

    if (HAS_SETCLR) begin : g_setclr
      cef_ctl_sampler #(.WIDTH(WIDTH), .POL(SET_POL)) u_set (
        .clk(gclk), .rst(grst), .raw(setb), .act_now(set_c), .act_smp(set_s)
      );
      cef_ctl_sampler #(.WIDTH(WIDTH), .POL(CLR_POL)) u_clr (
        .clk(gclk), .rst(grst), .raw(clrb), .act_now(clr_c), .act_smp(clr_s)
      );
    end else begin : g_no_setclr
      logic sr_unused;
      assign sr_unused = ^{setb, clrb};
      assign set_s = '0;
      assign set_c = '0;
      assign clr_s = '0;
      assign clr_c = '0;
    end

    if (HAS_ARST) begin : g_arst
      cef_ctl_sampler #(.WIDTH(1), .POL(ARST_POL)) u_rst (
        .clk(gclk), .rst(grst), .raw(arst), .act_now(rst_c), .act_smp(rst_s)
      );
    end else begin : g_no_arst
      logic arst_unused;
      assign arst_unused = arst;
      assign rst_s = 1'b0;
      assign rst_c = 1'b0;
    end
  endgenerate

  // Clock-edge selection comes before both control passes.
  assign edge_q = clk_hit ? d_smp : q_smp;

  cef_pass_stage #(
    .WIDTH(WIDTH), .HAS_LOAD(HAS_LOAD), .HAS_SETCLR(HAS_SETCLR),
    .HAS_ARST(HAS_ARST), .RST_VAL(RST_VAL)
  ) u_pass_smp (
    .q_in(edge_q), .ld(ld_s), .ld_data(ldd_s), .set(set_s), .clr(clr_s),
    .rst(rst_s), .q_out(mid_q)
  );

  cef_pass_stage #(
    .WIDTH(WIDTH), .HAS_LOAD(HAS_LOAD), .HAS_SETCLR(HAS_SETCLR),
    .HAS_ARST(HAS_ARST), .RST_VAL(RST_VAL)
  ) u_pass_cur (
    .q_in(mid_q), .ld(ld_c), .ld_data(ldd_c), .set(set_c), .clr(clr_c),
    .rst(rst_c), .q_out(q)
  );
endmodule

// File: rtl/cef_checker.sv
module cef_checker #(
  parameter int               WIDTH      = 8,
  parameter logic             CLK_POL    = 1'b1,
  parameter bit               HAS_LOAD   = 1'b1,
  parameter logic             LOAD_POL   = 1'b1,
  parameter bit               HAS_SETCLR = 1'b1,
  parameter logic             SET_POL    = 1'b1,
  parameter logic             CLR_POL    = 1'b1,
  parameter bit               HAS_ARST   = 1'b1,
  parameter logic             ARST_POL   = 1'b0,
  parameter logic [WIDTH-1:0] RST_VAL    = WIDTH'('hA5)
) (
  input logic             gclk,
  input logic             grst,
  input logic             emu_clk,
  input logic [WIDTH-1:0] din,
  input logic             ld,
  input logic [WIDTH-1:0] ld_din,
  input logic [WIDTH-1:0] setb,
  input logic [WIDTH-1:0] clrb,
  input logic             arst,
  input logic [WIDTH-1:0] q
);
  logic             ld_a, rst_a, quiet;
  logic [WIDTH-1:0] set_a, clr_a;

  assign ld_a  = HAS_LOAD   && (ld == LOAD_POL);
  assign rst_a = HAS_ARST   && (arst == ARST_POL);
  assign set_a = HAS_SETCLR ? (SET_POL ? setb : ~setb) : '0;
  assign clr_a = HAS_SETCLR ? (CLR_POL ? clrb : ~clrb) : '0;
  assign quiet = !ld_a && !rst_a && (set_a == '0) && (clr_a == '0);

  // R3: a quiet edge shows last cycle's data
  a_r3_edge_takes_past_data: assert property (@(posedge gclk) disable iff (grst)
    (!$past(grst) && quiet && $past(quiet) &&
     (emu_clk == CLK_POL) && ($past(emu_clk) != CLK_POL))
    |-> (q == $past(din)));

  // R1: without edge or control, q holds
  a_r1_hold_when_idle: assert property (@(posedge gclk) disable iff (grst)
    (!$past(grst) && quiet && $past(quiet) &&
     !((emu_clk == CLK_POL) && ($past(emu_clk) != CLK_POL)))
    |-> (q == $past(q)));

  generate
    if (HAS_ARST) begin : g_rst_chk
      // R8: active reset forces the reset value
      a_r8_reset_forces: assert property (@(posedge gclk) disable iff (grst)
        rst_a |-> (q == RST_VAL));
      // R9: reset value persists through the release cycle
      a_r9_negative_hold: assert property (@(posedge gclk) disable iff (grst)
        (!$past(grst) && $past(rst_a) && !ld_a && (set_a == '0) && (clr_a == '0))
        |-> (q == RST_VAL));
    end
    if (HAS_SETCLR) begin : g_sr_chk
      // R7: clear dominates set on each bit
      a_r7_clear_wins: assert property (@(posedge gclk) disable iff (grst)
        (!rst_a && !$past(rst_a)) |-> ((q & clr_a) == '0));
    end
    if (HAS_LOAD) begin : g_ld_chk
      // R6: current load shows the live load data
      a_r6_load_live: assert property (@(posedge gclk) disable iff (grst)
        (ld_a && !rst_a && !$past(rst_a) && (set_a == '0) && (clr_a == '0))
        |-> (q == ld_din));
    end
  endgenerate
endmodule

bind clk_emu_ff cef_checker #(
  .WIDTH(WIDTH), .CLK_POL(CLK_POL), .HAS_LOAD(HAS_LOAD), .LOAD_POL(LOAD_POL),
  .HAS_SETCLR(HAS_SETCLR), .SET_POL(SET_POL), .CLR_POL(CLR_POL),
  .HAS_ARST(HAS_ARST), .ARST_POL(ARST_POL), .RST_VAL(RST_VAL)
) u_cef_checker (
  .gclk(gclk), .grst(grst), .emu_clk(emu_clk), .din(din), .ld(ld),
  .ld_din(ld_din), .setb(setb), .clrb(clrb), .arst(arst), .q(q)
);

// File: tb/test_clk_emu_ff.sv
`timescale 1ns/1ps
module test_clk_emu_ff;
  localparam logic [7:0] RV  = 8'hA5;
  localparam logic [7:0] IV  = 8'h3C;
  localparam logic [7:0] IVB = 8'h5A;

  logic gclk = 1'b0;
  logic grst = 1'b1;
  logic emu_clk = 1'b0, ld = 1'b0, arst_n = 1'b1;
  logic [7:0] din = '0, ld_din = '0, setb = '0, clrb = '0;
  logic [7:0] q, qb;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 gclk = ~gclk;

  clk_emu_ff i_clk_emu_ff (
    .gclk(gclk), .grst(grst), .emu_clk(emu_clk), .din(din), .ld(ld),
    .ld_din(ld_din), .setb(setb), .clrb(clrb), .arst(arst_n), .q(q)
  );

  // Second build: falling-edge clock, every optional control switched off.
  clk_emu_ff #(
    .CLK_POL(1'b0), .HAS_LOAD(1'b0), .HAS_SETCLR(1'b0), .HAS_ARST(1'b0),
    .INIT_VAL(IVB)
  ) i_clk_emu_ff_bare (
    .gclk(gclk), .grst(grst), .emu_clk(emu_clk), .din(din), .ld(ld),
    .ld_din(ld_din), .setb(setb), .clrb(clrb), .arst(arst_n), .q(qb)
  );

  // Reference state: values registered at the last rising edge.
  logic [7:0] mq = IV, md = '0, mad = '0, mset = '0, mclr = '0;
  logic       mclk = 1'b1, mld = 1'b0, marst = 1'b0;
  logic [7:0] mqb = IVB, mdb = '0;
  logic       mclkb = 1'b0;

  function automatic logic [7:0] ref_main();
    logic [7:0] t;
    t = (!mclk && emu_clk) ? md : mq;
    t = mld ? mad : t;
    t = (t | mset) & ~mclr;
    t = marst ? RV : t;
    t = ld ? ld_din : t;
    t = (t | setb) & ~clrb;
    t = !arst_n ? RV : t;
    return t;
  endfunction

  function automatic logic [7:0] ref_bare();
    return (mclkb && !emu_clk) ? mdb : mqb;
  endfunction

  function automatic string auto_tag();
    if (!arst_n) return "R8";
    if (marst) return "R9";
    if (ld || mld) return "R6";
    if ((setb | clrb | mset | mclr) != '0) return "R7";
    if (!mclk && emu_clk) return "R3";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: q=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs are already set after a falling edge; check, advance model, wait.
  task automatic cyc(input string tag, input bit lit_en, input logic [7:0] lit);
    logic [7:0] e, eb;
    #1;
    e  = ref_main();
    eb = ref_bare();
    chk(tag == "" ? auto_tag() : tag, q, e);
    chk("R10", qb, eb);
    if (lit_en) chk(tag, q, lit);
    if (grst) begin
      mq = IV; mclk = 1'b1; md = '0; mad = '0; mld = 1'b0;
      mset = '0; mclr = '0; marst = 1'b0;
      mqb = IVB; mclkb = 1'b0; mdb = '0;
    end else begin
      mq = e; mclk = emu_clk; md = din; mad = ld_din; mld = ld;
      mset = setb; mclr = clrb; marst = !arst_n;
      mqb = eb; mclkb = emu_clk; mdb = din;
    end
    @(negedge gclk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: q=%h expected completion", q);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    @(negedge gclk);
    // R1: reset state, inputs idle
    cyc("R1", 1, IV);
    cyc("R1", 1, IV);
    // R2: clock already high at release must not count as an edge
    grst = 1'b0; emu_clk = 1'b1; din = 8'hFF;
    cyc("R2", 1, IV);
    // R3: edge takes the previous cycle's data
    emu_clk = 1'b0; din = 8'h11; cyc("R3", 1, IV);
    emu_clk = 1'b1; din = 8'h22; cyc("R3", 1, 8'h11);
    cyc("R1", 1, 8'h11);
    // R6: load with live data, then sampled load data one cycle later
    ld = 1'b1; ld_din = 8'h77; cyc("R6", 1, 8'h77);
    ld = 1'b0; ld_din = 8'h00; cyc("R6", 1, 8'h77);
    // R7: set and clear on overlapping bits, clear wins
    setb = 8'h0F; clrb = 8'h03; cyc("R7", 1, 8'h7C);
    setb = 8'h00; clrb = 8'h00; cyc("R7", 1, 8'h7C);
    // R4 R8: active-low reset forces reset value
    emu_clk = 1'b0; arst_n = 1'b0; cyc("R8", 1, RV);
    // R9: release together with an edge, data ignored
    arst_n = 1'b1; emu_clk = 1'b1; din = 8'h99; cyc("R9", 1, RV);
    cyc("R9", 1, RV);
    // R5: sampled clear is overridden by a current load
    clrb = 8'hFF; cyc("R5", 1, 8'h00);
    clrb = 8'h00; ld = 1'b1; ld_din = 8'h3C; cyc("R5", 1, 8'h3C);
    ld = 1'b0; cyc("R5", 1, 8'h3C);
    // R4: active-high controls, active-low reset held inactive at 1
    setb = 8'h80; cyc("R4", 1, 8'hBC);
    setb = 8'h00; cyc("R4", 1, 8'hBC);
    // R10: bare build ignores all control pins
    ld = 1'b1; ld_din = 8'h01; setb = 8'hFF; clrb = 8'hF0; arst_n = 1'b0;
    cyc("R10", 0, '0);
    ld = 1'b0; setb = '0; clrb = '0; arst_n = 1'b1; cyc("", 0, '0);

    for (int i = 0; i < 4000; i++) begin
      grst    = (i == 2000);
      emu_clk = $urandom_range(0, 1) != 0;
      din     = 8'($urandom);
      ld      = $urandom_range(0, 15) == 0;
      ld_din  = 8'($urandom);
      arst_n  = $urandom_range(0, 15) != 0;
      setb    = ($urandom_range(0, 3) == 0) ? 8'($urandom & $urandom & $urandom) : '0;
      clrb    = ($urandom_range(0, 3) == 0) ? 8'($urandom & $urandom & $urandom) : '0;
      cyc("", 0, '0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule